// File: doc/BRIEF.md
# Configurable Registered Command Buffer

This block registers the command and address lanes of a memory module on the rising edge of the clock. It works in one of two widths. In the wide mode it is a 25-lane register with one output per lane. In the duplicated mode only the lower 14 lanes are active, and each registered lane drives two identical outputs, side A and side B. This lets one register feed two halves of a module.

In the duplicated mode, a second configuration input chooses where the clock-enable and on-die-termination signals sit among the lanes. The chip-select signal always sits on the same lane. Ordinary data lanes stop changing while both chip-select inputs are high. The clock-enable, termination and chip-select lanes keep updating at every edge. An asynchronous active-low reset clears every register and drives all outputs low. Reset overrides the chip-select gating.

Top module: `cmd_reg_buf`

## Requirements
- R1: While `rst_ni` is low, `q_a_o` and `q_b_o` are all zero. This holds without waiting for a clock edge, and it holds even when the chip-select gating would otherwise keep the data lanes.
- R2: With `dup_mode_i`=0, each ordinary data lane k presents `lane_i[k]` on `q_a_o[k]` after the rising edge that captured it. The ordinary data lanes are every bit from 0 to 24 except bits 0, 3 and 6.
- R3: With `dup_mode_i`=0, or with `dup_mode_i`=1 and `map_b_i`=0, the captured values sit on fixed bits: `cke_i` on bit 0, `odt_i` on bit 3 and `cs_n_i` on bit 6. The `lane_i` values on those three bits are ignored.
- R4: With `dup_mode_i`=1 and `map_b_i`=1, bits 0 and 3 are ordinary data lanes. `odt_i` is carried on bit 10, `cke_i` on bit 13 and `cs_n_i` on bit 6. The `lane_i` values on bits 10 and 13 are ignored.
- R5: With `dup_mode_i`=1, `q_b_o[13:0]` equals `q_a_o[13:0]`. Bits 24 to 14 of both outputs are 0, and `lane_i[24:14]` has no effect.
- R6: With `dup_mode_i`=0, `q_b_o` is all zero.
- R7: At a rising edge where `cs_n_i`=1 and `cs_gate_i`=1, every ordinary data lane keeps its previous value. At an edge where either of the two is 0, the data lanes load normally.
- R8: The clock-enable, termination and chip-select lanes load at every rising edge, whatever the state of `cs_n_i` and `cs_gate_i`.
- R9: A change on `dup_mode_i` or `map_b_i` does not change the outputs between clock edges. The change takes effect at the next rising edge.
- R10: Suppose `rst_ni` rises while `lane_i`, `cke_i`, `odt_i` and `cs_n_i` are all 0. The outputs then stay at zero at every following edge, with no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dup_mode_i | input | 1 | 0: 25-lane one-to-one, 1: 14-lane duplicated |
| map_b_i | input | 1 | Lane mapping select in duplicated mode |
| cs_n_i | input | 1 | Chip select, registered onto bit 6 |
| cs_gate_i | input | 1 | Enables data hold when `cs_n_i` is also high |
| cke_i | input | 1 | Clock-enable input |
| odt_i | input | 1 | On-die-termination input |
| lane_i | input | 25 | Lane inputs, bit k is lane k+1 |
| q_a_o | output | 25 | Registered side-A outputs |
| q_b_o | output | 25 | Side-B copy, zero in one-to-one mode |

## Verification
Every registered result appears one rising edge after it is captured. The bench therefore drives inputs on a falling edge and compares the outputs on the next falling edge, which lies exactly one capture later. Reset is the only path with no clock in it. Its check is made a nanosecond after `rst_ni` falls, in the middle of a cycle. Configuration changes are checked twice: once between edges, where nothing may move, and once on the falling edge after the next capture.

// File: rtl/cmd_buf_pkg.sv
package cmd_buf_pkg;
  parameter int unsigned NUM_LANES = 25;
  parameter int unsigned DUP_LANES = 14;
  // fixed control positions (bit index = lane - 1)
  parameter int unsigned CS_POS    = 6;
  parameter int unsigned CKE_POS_A = 0;
  parameter int unsigned ODT_POS_A = 3;
  parameter int unsigned ODT_POS_B = 10;
  parameter int unsigned CKE_POS_B = 13;

  typedef enum logic [2:0] {
    ROLE_DATA,
    ROLE_CKE,
    ROLE_ODT,
    ROLE_CS,
    ROLE_OFF
  } lane_role_e;

  function automatic lane_role_e lane_role(input int unsigned k, input logic dup,
                                           input logic map_b, input int unsigned nd);
    lane_role_e r;
    r = ROLE_DATA;
    if (dup && k >= nd)                       r = ROLE_OFF;
    else if (k == CS_POS)                     r = ROLE_CS;
    else if (!(dup && map_b) && k == CKE_POS_A) r = ROLE_CKE;
    else if (!(dup && map_b) && k == ODT_POS_A) r = ROLE_ODT;
    else if (dup && map_b && k == CKE_POS_B)  r = ROLE_CKE;
    else if (dup && map_b && k == ODT_POS_B)  r = ROLE_ODT;
    return r;
  endfunction
endpackage

// File: rtl/cmd_lane_map.sv
module cmd_lane_map
  import cmd_buf_pkg::*;
#(
  parameter int unsigned NL = NUM_LANES,
  parameter int unsigned ND = DUP_LANES
) (
  input  logic          dup_i,
  input  logic          map_b_i,
  input  logic [NL-1:0] lane_i,
  input  logic          cke_i,
  input  logic          odt_i,
  input  logic          cs_n_i,
  output logic [NL-1:0] nxt_o,
  output logic [NL-1:0] ctl_o   // 1: lane loads every edge, bypasses hold
);
  for (genvar k = 0; k < NL; k++) begin : g_lane
    lane_role_e role;
    always_comb begin
      role     = lane_role(k, dup_i, map_b_i, ND);
      nxt_o[k] = 1'b0;
      ctl_o[k] = 1'b1;
      unique case (role)
        ROLE_DATA: begin
          nxt_o[k] = lane_i[k];
          ctl_o[k] = 1'b0;
        end
        ROLE_CKE: nxt_o[k] = cke_i;
        ROLE_ODT: nxt_o[k] = odt_i;
        ROLE_CS:  nxt_o[k] = cs_n_i;
        default:  nxt_o[k] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/cmd_lane_reg.sv
module cmd_lane_reg #(
  parameter int unsigned NL = 25
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic [NL-1:0] nxt_i,
  input  logic [NL-1:0] ctl_i,
  output logic [NL-1:0] q_o
);
  for (genvar k = 0; k < NL; k++) begin : g_ff
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 q_o[k] <= 1'b0;
      else if (ctl_i[k] || !hold_i) q_o[k] <= nxt_i[k];
    end
  end
endmodule

// File: rtl/cmd_out_fanout.sv
module cmd_out_fanout #(
  parameter int unsigned NL = 25,
  parameter int unsigned ND = 14
) (
  input  logic          mode_i,
  input  logic [NL-1:0] q_i,
  output logic [NL-1:0] q_a_o,
  output logic [NL-1:0] q_b_o
);
  assign q_a_o = q_i;
  for (genvar k = 0; k < NL; k++) begin : g_b
    if (k < ND) begin : g_copy
      assign q_b_o[k] = mode_i & q_i[k];
    end else begin : g_zero
      assign q_b_o[k] = 1'b0;
    end
  end
endmodule

// File: rtl/cmd_reg_buf.sv
module cmd_reg_buf
  import cmd_buf_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 dup_mode_i,
  input  logic                 map_b_i,
  input  logic                 cs_n_i,
  input  logic                 cs_gate_i,
  input  logic                 cke_i,
  input  logic                 odt_i,
  input  logic [NUM_LANES-1:0] lane_i,
  output logic [NUM_LANES-1:0] q_a_o,
  output logic [NUM_LANES-1:0] q_b_o
);
  localparam int unsigned NL = NUM_LANES;
  localparam int unsigned ND = DUP_LANES;

  logic [NL-1:0] nxt, ctl, q;
  logic          mode_q;
  logic          hold;

  assign hold = cs_n_i & cs_gate_i;

  // registered mode so a config change lands with the data it governs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= dup_mode_i;
  end

  cmd_lane_map #(.NL(NL), .ND(ND)) u_map (
    .dup_i   (dup_mode_i),
    .map_b_i (map_b_i),
    .lane_i  (lane_i),
    .cke_i   (cke_i),
    .odt_i   (odt_i),
    .cs_n_i  (cs_n_i),
    .nxt_o   (nxt),
    .ctl_o   (ctl)
  );

  cmd_lane_reg #(.NL(NL)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold),
    .nxt_i  (nxt),
    .ctl_i  (ctl),
    .q_o    (q)
  );

  cmd_out_fanout #(.NL(NL), .ND(ND)) u_fan (
    .mode_i (mode_q),
    .q_i    (q),
    .q_a_o  (q_a_o),
    .q_b_o  (q_b_o)
  );

  // R1
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      rst_out_chk: assert (q_a_o == '0 && q_b_o == '0);
    end
  end

  // R6
  b_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dup_mode_i |=> q_b_o == '0);

  // R5
  dup_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dup_mode_i |=> (q_b_o[ND-1:0] == q_a_o[ND-1:0]) && (q_a_o[NL-1:ND] == '0));

  // R4
  map_b_cke_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dup_mode_i && map_b_i) |=> q_a_o[CKE_POS_B] == $past(cke_i));

  // R8
  cs_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> q_a_o[CS_POS] == $past(cs_n_i));

  // R7
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_i && cs_gate_i) |=> $stable(q_a_o[2:1]));
endmodule

// File: tb/tb_cmd_reg_buf.sv
module tb_cmd_reg_buf;
  localparam int NL = 25;
  localparam int ND = 14;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic dup, mb, csn, gate, cke, odt;
  logic [NL-1:0] lane;
  logic [NL-1:0] q_a, q_b, exp_a, exp_b;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  cmd_reg_buf dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .dup_mode_i(dup), .map_b_i(mb),
    .cs_n_i(csn), .cs_gate_i(gate), .cke_i(cke), .odt_i(odt),
    .lane_i(lane), .q_a_o(q_a), .q_b_o(q_b)
  );

  // 0 data, 1 cke, 2 odt, 3 cs, 4 unused
  function automatic int role(int k, logic d, logic b);
    if (d && k >= ND) return 4;
    if (k == 6) return 3;
    if (!(d && b)) begin
      if (k == 0) return 1;
      if (k == 3) return 2;
    end else begin
      if (k == 13) return 1;
      if (k == 10) return 2;
    end
    return 0;
  endfunction

  task automatic chk(string tag, logic [NL-1:0] act, logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // update model for the coming edge, then wait through it
  task automatic tick();
    logic h;
    logic [NL-1:0] n;
    h = csn & gate;
    for (int k = 0; k < NL; k++) begin
      case (role(k, dup, mb))
        0: n[k] = h ? exp_a[k] : lane[k];
        1: n[k] = cke;
        2: n[k] = odt;
        3: n[k] = csn;
        default: n[k] = 1'b0;
      endcase
    end
    exp_a = n;
    exp_b = dup ? {{(NL-ND){1'b0}}, n[ND-1:0]} : '0;
    @(negedge clk_i);
  endtask

  task automatic chk_both(string tag);
    chk({tag, " side A"}, q_a, exp_a);
    chk({tag, " side B"}, q_b, exp_b);
  endtask

  task automatic set_in(logic [NL-1:0] l, logic c, logic o, logic s, logic g);
    lane = l; cke = c; odt = o; csn = s; gate = g;
  endtask

  task automatic t_reset_entry();
    dup = 0; mb = 0;
    set_in(25'h1FF_FFFF, 1, 1, 1, 0);
    tick();
    set_in(25'h000_0000, 0, 0, 1, 1);
    #2 rst_ni = 0;
    #1 chk("R1 async clear under hold", q_a, '0);
    chk("R1 side B clear", q_b, '0);
    exp_a = '0; exp_b = '0;
    @(negedge clk_i);
    chk("R1 held in reset", q_a, '0);
  endtask

  task automatic t_release();
    set_in('0, 0, 0, 0, 0);
    dup = 0; mb = 0;
    #2 rst_ni = 1;
    @(negedge clk_i);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R10 quiet release A", q_a, '0);
      chk("R10 quiet release B", q_b, '0);
    end
  endtask

  task automatic t_one2one();
    dup = 0; mb = 1;
    set_in(25'h0AA_AAAA, 1, 0, 1, 0);
    tick(); chk_both("R2 R3 R6 pattern 1");
    set_in(25'h155_5555, 0, 1, 0, 1);
    tick(); chk_both("R2 R3 R6 pattern 2");
    // control positions driven opposite on lane_i
    set_in(25'h1FF_FFB6 | 25'h49, 0, 0, 0, 0);
    tick();
    chk("R3 control bits ignore lanes", {22'b0, q_a[6], q_a[3], q_a[0]}, '0);
    chk("R2 all data ones", q_a & ~25'h49, 25'h1FF_FFFF & ~25'h49);
    chk("R6 B off", q_b, '0);
  endtask

  task automatic t_dup_a();
    dup = 1; mb = 0;
    set_in(25'h1FF_FFFF, 1, 1, 0, 0);
    tick(); chk_both("R5 R3 map A all ones");
    chk("R5 upper zero", q_a & 25'h1FF_C000, '0);
    chk("R5 B copy", q_b[ND-1:0], q_a[ND-1:0]);
    set_in(25'h123_4567, 0, 1, 1, 0);
    tick(); chk_both("R5 map A pattern");
  endtask

  task automatic t_dup_b();
    dup = 1; mb = 1;
    set_in(25'h000_2409 ^ 25'h1FF_FFFF, 1, 0, 0, 0);
    tick(); chk_both("R4 map B pattern 1");
    chk("R4 cke on bit 13", 25'(q_a[13]), 25'(1));
    chk("R4 odt on bit 10", 25'(q_a[10]), 25'(0));
    set_in(25'h000_0009, 0, 1, 1, 0);
    tick(); chk_both("R4 map B data on 0 and 3");
  endtask

  task automatic t_hold();
    dup = 0; mb = 0;
    set_in(25'h0F0_F0F0, 0, 0, 0, 0);
    tick();
    set_in(25'h10F_0F0F, 1, 1, 1, 1);
    tick(); chk_both("R7 R8 held data, controls move");
    set_in(25'h155_5555, 0, 0, 1, 1);
    tick(); chk_both("R7 R8 second held edge");
    set_in(25'h155_5555, 1, 0, 1, 0);
    tick(); chk_both("R7 gate low loads");
    set_in(25'h0AA_AAAA, 0, 1, 0, 1);
    tick(); chk_both("R7 cs low loads");
    dup = 1; mb = 1;
    tick();
    set_in(25'h000_3FFF, 1, 1, 1, 1);
    tick(); chk_both("R7 R8 hold in map B");
  endtask

  task automatic t_cfg_timing();
    logic [NL-1:0] pa, pb;
    dup = 0; mb = 0;
    set_in(25'h1FF_FFFF, 1, 1, 0, 0);
    tick();
    pa = q_a; pb = q_b;
    dup = 1; mb = 1;
    #1 chk("R9 A steady between edges", q_a, pa);
    chk("R9 B steady between edges", q_b, pb);
    tick(); chk_both("R9 dup applied at edge");
    pa = q_a; pb = q_b;
    dup = 0;
    #1 chk("R9 B steady after leaving dup", q_b, pb);
    tick(); chk_both("R9 R6 one-to-one applied at edge");
  endtask

  initial begin
    exp_a = '0; exp_b = '0;
    set_in('0, 0, 0, 0, 0);
    dup = 0; mb = 0;
    rst_ni = 1;
    #1 rst_ni = 0;
    @(negedge clk_i);
    chk("R1 reset state A", q_a, '0);
    chk("R1 reset state B", q_b, '0);
    t_release();
    t_one2one();
    t_dup_a();
    t_dup_b();
    t_hold();
    t_cfg_timing();
    t_reset_entry();
    t_release();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule